// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes a parameterised set of interrupt input lines (24 by default) to interrupt messages. Each line has its own 64-bit redirection entry that sets the vector, delivery mode, destination, input polarity, trigger style (edge or level) and a mask. A pin that becomes active is picked up by a per-pin detector. A fixed-priority arbiter then chooses one pending pin at a time and loads a message register. The register presents the vector, destination and delivery mode on a valid/ready output.

Software reaches the table only through an indirect window. It writes a register number to an index location, then reads or writes the chosen 32-bit word through a data location. A separate end-of-interrupt location takes a vector number. It re-arms level-triggered pins that wait on that vector, because a level pin sends no second message until software acknowledges the first. The low word of an entry holds the mask. Software therefore writes the high word first and the low word last, and a message always carries a fully written entry.

Top module: `irq_route_ctrl`

## Requirements
- R1: The byte offset on `reg_addr` selects the location: 0x00 is the index register (it reads back the last index written), 0x10 is the data window onto the indirect register that the index selects, 0x40 is the end-of-interrupt location, and every other offset reads as zero.
- R2: Pin p has its low word at index 0x10+2p and its high word at index 0x11+2p. The low word fields are: vector [7:0], delivery mode [10:8], logical-destination flag [11], active-low polarity [13], remote-IRR [14] (read-only), level trigger [15] and mask [16]. The high word holds the destination in [31:24]. All other bits read as zero.
- R3: Index 0x01 reads 0x00170020 with default parameters: version 0x20 in [7:0] and the highest entry number (pin count minus one) in [23:16].
- R4: After reset every entry reads 0x00010000 (masked, all other fields zero), every remote-IRR bit is clear, the index reads zero and `msg_valid` is low.
- R5: An unmasked level-triggered pin whose input is active and whose remote-IRR is clear raises a message. The handshake (`msg_valid` and `msg_ready` both high) sets that pin's remote-IRR. No further message leaves for that pin while remote-IRR stays set, even if the line stays active.
- R6: A write of vector V to offset 0x40 (V in data bits [7:0]) clears remote-IRR on every level-triggered entry whose vector equals V. Entries with another vector keep it. A level pin whose line is still active then sends a new message.
- R7: An end-of-interrupt write has no effect on the remote-IRR of an entry set to edge trigger.
- R8: An edge-triggered pin sends exactly one message for each inactive-to-active transition of its input. A line held active sends nothing more.
- R9: An edge that occurs while its pin is masked is dropped. Unmasking afterwards sends no message.
- R10: The input is active when high with polarity bit 0 and when low with polarity bit 1. Transitions into the inactive state send nothing.
- R11: When several pins request in the same cycle, the lowest-numbered pin is sent first.
- R12: A message is captured whole from the entry when it is launched. Its fields hold steady while `msg_valid` is high and `msg_ready` is low, even if software rewrites the entry in that time.
- R13: The 3-bit delivery mode is stored unchanged, including the SMI code 3'b010. It reads back as written and is carried on `msg_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 8 | Byte offset into the window (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_in | input | NPINS | Interrupt input lines |
| msg_valid | output | 1 | A message is presented |
| msg_ready | input | 1 | The receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_logical | output | 1 | Logical-destination flag of the message |
| msg_level | output | 1 | The message came from a level-triggered pin |

## Verification
The embedded properties check on every cycle the following: the end-of-interrupt clears remote-IRR on matching level entries and leaves edge entries alone; data writes cannot alter remote-IRR; the arbiter grants one pin and the lowest one; no pin is launched while its remote-IRR is set; a handshake on a level message sets the bit; a held message stays steady; and masked edges never become pending. The sequences themselves need the bench's scenarios. These are: the index/data addressing and the version word; the order of high- and low-word writes; re-delivery after an end-of-interrupt while the line is held active; polarity inversion; one message per edge; and the reset contents of the table.

// File: rtl/irt_pkg.sv
package irt_pkg;

   // register window byte offsets
   localparam logic [7:0] OFF_INDEX    = 8'h00;
   localparam logic [7:0] OFF_DATA     = 8'h10;
   localparam logic [7:0] OFF_EOI      = 8'h40;

   // indirect register numbers
   localparam logic [7:0] IDX_VERSION  = 8'h01;
   localparam logic [7:0] IDX_RTE_BASE = 8'h10;
   localparam logic [7:0] VERSION_ID   = 8'h20;

   // one redirection entry, as stored
   typedef struct packed {
      logic [7:0] dest;
      logic       mask;
      logic       level;
      logic       rirr;
      logic       act_low;
      logic       dst_logical;
      logic [2:0] mode;
      logic [7:0] vec;
   } rte_t;

   function automatic rte_t rte_reset_value();
      rte_t e;
      e      = '0;
      e.mask = 1'b1;
      return e;
   endfunction

   function automatic logic [31:0] rte_low_word(input rte_t e);
      return {15'b0, e.mask, e.level, e.rirr, e.act_low, 1'b0,
              e.dst_logical, e.mode, e.vec};
   endfunction

endpackage

// File: rtl/irt_rte_bank.sv
module irt_rte_bank
   import irt_pkg::*;
#(
   parameter int NPINS = 24,
   parameter int IDXW  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [NPINS-1:0] irr_set,
   output rte_t             rte_o [NPINS]
);

   localparam logic [8:0] IDX_END = 9'(IDX_RTE_BASE) + 9'(2 * NPINS);
   localparam logic [7:0] MAX_ENT = 8'(NPINS - 1);

   logic [7:0]      index_q;
   rte_t            rte_q [NPINS];
   logic            data_wr, eoi_wr, in_range, sel_hi;
   logic [7:0]      off;
   logic [IDXW-1:0] sel_pin;
   logic            unused_bank;

   assign data_wr  = reg_wr && (reg_addr == OFF_DATA);
   assign eoi_wr   = reg_wr && (reg_addr == OFF_EOI);
   assign off      = index_q - IDX_RTE_BASE;
   assign in_range = ({1'b0, index_q} >= {1'b0, IDX_RTE_BASE}) && ({1'b0, index_q} < IDX_END);
   assign sel_pin  = off[IDXW:1];
   assign sel_hi   = index_q[0];
   assign unused_bank = ^{reg_wdata[23:17], reg_wdata[14], reg_wdata[12], off};

   always_ff @(posedge clk) begin
      if (!rst_n)
         index_q <= '0;
      else if (reg_wr && (reg_addr == OFF_INDEX))
         index_q <= reg_wdata[7:0];
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_ent
      logic hit;
      logic eoi_hit;
      assign hit     = data_wr && in_range && (sel_pin == IDXW'(p));
      assign eoi_hit = eoi_wr && rte_q[p].level && (rte_q[p].vec == reg_wdata[7:0]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rte_q[p] <= rte_reset_value();
         end else begin
            if (hit && sel_hi) begin
               rte_q[p].dest <= reg_wdata[31:24];
            end else if (hit) begin
               rte_q[p].vec         <= reg_wdata[7:0];
               rte_q[p].mode        <= reg_wdata[10:8];
               rte_q[p].dst_logical <= reg_wdata[11];
               rte_q[p].act_low     <= reg_wdata[13];
               rte_q[p].level       <= reg_wdata[15];
               rte_q[p].mask        <= reg_wdata[16];
            end
            if (irr_set[p])
               rte_q[p].rirr <= 1'b1;
            else if (eoi_hit)
               rte_q[p].rirr <= 1'b0;
         end
      end

      assign rte_o[p] = rte_q[p];

      // R6: matching end-of-interrupt on a level entry clears remote-IRR
      a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_wr && rte_q[p].level && (rte_q[p].vec == reg_wdata[7:0]) && !irr_set[p])
         |=> !rte_q[p].rirr);

      // R7: end-of-interrupt leaves an edge entry's remote-IRR alone
      a_r7_edge_keeps_irr: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_wr && !rte_q[p].level && rte_q[p].rirr) |=> rte_q[p].rirr);

      // R2: remote-IRR is read-only through the data window
      a_r2_irr_readonly: assert property (@(posedge clk) disable iff (!rst_n)
         (data_wr && !irr_set[p]) |=> $stable(rte_q[p].rirr));
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFF_INDEX: reg_rdata = {24'b0, index_q};
         OFF_DATA: begin
            if (index_q == IDX_VERSION)
               reg_rdata = {8'h00, MAX_ENT, 8'h00, VERSION_ID};
            else if (in_range && sel_hi)
               reg_rdata = {rte_q[sel_pin].dest, 24'b0};
            else if (in_range)
               reg_rdata = rte_low_word(rte_q[sel_pin]);
         end
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irt_pin_detect.sv
module irt_pin_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic act_low_i,
   input  logic level_i,
   input  logic mask_i,
   input  logic rirr_i,
   input  logic grant_i,
   output logic req_o
);

   logic active, prev_q, pend_q, pend_d, rise;

   assign active = line_i ^ act_low_i;
   assign rise   = active & ~prev_q;

   always_comb begin
      if (level_i)
         pend_d = 1'b0;
      else if (grant_i)
         pend_d = pend_q & rise & ~mask_i;
      else
         pend_d = pend_q | (rise & ~mask_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= active;
         pend_q <= pend_d;
      end
   end

   assign req_o = level_i ? (active & ~mask_i & ~rirr_i)
                          : ((pend_q | rise) & ~mask_i);

   // R9: an edge seen while masked never becomes pending
   a_r9_masked_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i && !pend_q) |=> !pend_q);

   // R8: a granted edge with nothing queued leaves nothing behind
   a_r8_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_i && !level_i && !pend_q) |=> !pend_q);

endmodule

// File: rtl/irt_prio_arb.sv
module irt_prio_arb #(
   parameter int NPINS = 24,
   parameter int IDXW  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] req_i,
   output logic [NPINS-1:0] gnt_o,
   output logic [IDXW-1:0]  gnt_idx_o,
   output logic             any_o
);

   always_comb begin
      gnt_o     = '0;
      gnt_idx_o = '0;
      any_o     = 1'b0;
      for (int i = NPINS - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            gnt_o     = '0;
            gnt_o[i]  = 1'b1;
            gnt_idx_o = IDXW'(i);
            any_o     = 1'b1;
         end
      end
   end

   // R11: at most one grant, and no lower-numbered request is passed over
   a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o));
   a_r11_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ((req_i & (gnt_o - 1'b1)) == '0));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irt_pkg::*;
#(
   parameter int NPINS = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [NPINS-1:0] irq_in,
   output logic             msg_valid,
   input  logic             msg_ready,
   output logic [7:0]       msg_vector,
   output logic [7:0]       msg_dest,
   output logic [2:0]       msg_mode,
   output logic             msg_dest_logical,
   output logic             msg_level
);

   localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1;

   if (NPINS < 1 || NPINS > 120) begin : g_bad_npins
      $error("irq_route_ctrl: NPINS must lie in 1..120 to fit the 8-bit index");
   end

   rte_t             rte [NPINS];
   logic [NPINS-1:0] req, gnt, grant_vec, irr_set, rirr_v, level_v;
   logic [IDXW-1:0]  gnt_idx;
   logic             gnt_any, launch;

   logic             valid_q, level_q, dlog_q;
   logic [7:0]       vec_q, dest_q;
   logic [2:0]       mode_q;
   logic [NPINS-1:0] pin_q;

   irt_rte_bank #(.NPINS(NPINS), .IDXW(IDXW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irr_set   (irr_set),
      .rte_o     (rte)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      irt_pin_detect u_det (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_i    (irq_in[p]),
         .act_low_i (rte[p].act_low),
         .level_i   (rte[p].level),
         .mask_i    (rte[p].mask),
         .rirr_i    (rte[p].rirr),
         .grant_i   (grant_vec[p]),
         .req_o     (req[p])
      );
      assign rirr_v[p]  = rte[p].rirr;
      assign level_v[p] = rte[p].level;
   end

   irt_prio_arb #(.NPINS(NPINS), .IDXW(IDXW)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .gnt_o     (gnt),
      .gnt_idx_o (gnt_idx),
      .any_o     (gnt_any)
   );

   assign launch    = gnt_any & ~valid_q;
   assign grant_vec = launch ? gnt : '0;
   assign irr_set   = (valid_q && msg_ready && level_q) ? pin_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         level_q <= 1'b0;
         dlog_q  <= 1'b0;
         vec_q   <= '0;
         dest_q  <= '0;
         mode_q  <= '0;
         pin_q   <= '0;
      end else if (launch) begin
         valid_q <= 1'b1;
         level_q <= rte[gnt_idx].level;
         dlog_q  <= rte[gnt_idx].dst_logical;
         vec_q   <= rte[gnt_idx].vec;
         dest_q  <= rte[gnt_idx].dest;
         mode_q  <= rte[gnt_idx].mode;
         pin_q   <= gnt;
      end else if (valid_q && msg_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign msg_valid        = valid_q;
   assign msg_vector       = vec_q;
   assign msg_dest         = dest_q;
   assign msg_mode         = mode_q;
   assign msg_dest_logical = dlog_q;
   assign msg_level        = level_q;

   // R12: a presented message holds until it is taken
   a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_vector, msg_dest, msg_mode, msg_level})));

   // R5: no launch for a level pin that still waits on its end-of-interrupt
   a_r5_no_launch_irr: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> ((gnt & rirr_v & level_v) == '0));

   // R5: taking a level message sets that pin's remote-IRR
   a_r5_irr_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && msg_level) |=> ((rirr_v & $past(pin_q)) != '0));

endmodule

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;

   localparam int NPINS    = 24;
   localparam int WATCHDOG = 20000;

   localparam logic [3:0] OP_WR  = 4'd1;
   localparam logic [3:0] OP_RD  = 4'd2;
   localparam logic [3:0] OP_PIN = 4'd3;
   localparam logic [3:0] OP_MSG = 4'd4;
   localparam logic [3:0] OP_NOM = 4'd5;

   // {op, requirement number, offset, data, expected}
   localparam int N_VEC = 61;
   localparam logic [79:0] VECS [N_VEC] = '{
      {OP_WR,  4'd3,  8'h00, 32'h00000001, 32'h0},          // R3 version
      {OP_RD,  4'd3,  8'h10, 32'h0,        32'h00170020},
      {OP_RD,  4'd1,  8'h00, 32'h0,        32'h00000001},   // R1 index readback
      {OP_RD,  4'd1,  8'h20, 32'h0,        32'h00000000},   // R1 unused offset
      {OP_WR,  4'd4,  8'h00, 32'h00000010, 32'h0},          // R4 pin 0 at reset
      {OP_RD,  4'd4,  8'h10, 32'h0,        32'h00010000},
      {OP_WR,  4'd2,  8'h00, 32'h0000003E, 32'h0},          // R2 last entry low
      {OP_RD,  4'd2,  8'h10, 32'h0,        32'h00010000},
      {OP_WR,  4'd2,  8'h00, 32'h00000017, 32'h0},          // R2 pin 3 high word
      {OP_WR,  4'd2,  8'h10, 32'h05000000, 32'h0},
      {OP_RD,  4'd2,  8'h10, 32'h0,        32'h05000000},
      {OP_WR,  4'd2,  8'h00, 32'h00000016, 32'h0},
      {OP_WR,  4'd5,  8'h10, 32'h00008041, 32'h0},          // R5 level, unmasked
      {OP_NOM, 4'd5,  8'h00, 32'h0,        32'h0},
      {OP_PIN, 4'd5,  8'h00, 32'h00000008, 32'h0},
      {OP_MSG, 4'd5,  8'h00, 32'h0,        32'h00000541},
      {OP_RD,  4'd5,  8'h10, 32'h0,        32'h0000C041},
      {OP_NOM, 4'd5,  8'h00, 32'h0,        32'h0},          // R5 held line, no repeat
      {OP_WR,  4'd6,  8'h40, 32'h00000042, 32'h0},          // R6 wrong vector
      {OP_NOM, 4'd6,  8'h00, 32'h0,        32'h0},
      {OP_RD,  4'd6,  8'h10, 32'h0,        32'h0000C041},
      {OP_WR,  4'd6,  8'h40, 32'h00000041, 32'h0},          // R6 matching vector
      {OP_MSG, 4'd6,  8'h00, 32'h0,        32'h00000541},
      {OP_PIN, 4'd6,  8'h00, 32'h00000000, 32'h0},
      {OP_WR,  4'd6,  8'h40, 32'h00000041, 32'h0},
      {OP_NOM, 4'd6,  8'h00, 32'h0,        32'h0},
      {OP_RD,  4'd6,  8'h10, 32'h0,        32'h00008041},
      {OP_PIN, 4'd7,  8'h00, 32'h00000008, 32'h0},          // R7 set IRR then go edge
      {OP_MSG, 4'd7,  8'h00, 32'h0,        32'h00000541},
      {OP_WR,  4'd7,  8'h10, 32'h00000041, 32'h0},
      {OP_RD,  4'd7,  8'h10, 32'h0,        32'h00004041},
      {OP_WR,  4'd7,  8'h40, 32'h00000041, 32'h0},
      {OP_RD,  4'd7,  8'h10, 32'h0,        32'h00004041},
      {OP_WR,  4'd7,  8'h10, 32'h00010041, 32'h0},
      {OP_PIN, 4'd7,  8'h00, 32'h00000000, 32'h0},
      {OP_PIN, 4'd10, 8'h00, 32'h00000020, 32'h0},          // R10 pin 5 active low
      {OP_WR,  4'd10, 8'h00, 32'h0000001A, 32'h0},
      {OP_WR,  4'd10, 8'h10, 32'h00002060, 32'h0},
      {OP_NOM, 4'd10, 8'h00, 32'h0,        32'h0},
      {OP_PIN, 4'd8,  8'h00, 32'h00000000, 32'h0},          // R8 falling line = edge
      {OP_MSG, 4'd8,  8'h00, 32'h0,        32'h00000060},
      {OP_NOM, 4'd8,  8'h00, 32'h0,        32'h0},
      {OP_PIN, 4'd10, 8'h00, 32'h00000020, 32'h0},
      {OP_NOM, 4'd10, 8'h00, 32'h0,        32'h0},
      {OP_PIN, 4'd8,  8'h00, 32'h00000000, 32'h0},
      {OP_MSG, 4'd8,  8'h00, 32'h0,        32'h00000060},
      {OP_WR,  4'd9,  8'h10, 32'h00012060, 32'h0},          // R9 edge while masked
      {OP_PIN, 4'd9,  8'h00, 32'h00000020, 32'h0},
      {OP_PIN, 4'd9,  8'h00, 32'h00000000, 32'h0},
      {OP_WR,  4'd9,  8'h10, 32'h00002060, 32'h0},
      {OP_NOM, 4'd9,  8'h00, 32'h0,        32'h0},
      {OP_WR,  4'd11, 8'h00, 32'h00000012, 32'h0},          // R11 pins 1 and 2
      {OP_WR,  4'd11, 8'h10, 32'h00008021, 32'h0},
      {OP_WR,  4'd11, 8'h00, 32'h00000014, 32'h0},
      {OP_WR,  4'd11, 8'h10, 32'h00008022, 32'h0},
      {OP_PIN, 4'd11, 8'h00, 32'h00000006, 32'h0},
      {OP_MSG, 4'd11, 8'h00, 32'h0,        32'h00000021},
      {OP_MSG, 4'd11, 8'h00, 32'h0,        32'h00000022},
      {OP_PIN, 4'd11, 8'h00, 32'h00000000, 32'h0},
      {OP_WR,  4'd11, 8'h40, 32'h00000021, 32'h0},
      {OP_WR,  4'd11, 8'h40, 32'h00000022, 32'h0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [7:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [NPINS-1:0] irq_in = '0;
   logic             msg_valid, msg_ready = 1'b0;
   logic [7:0]       msg_vector, msg_dest;
   logic [2:0]       msg_mode;
   logic             msg_dest_logical, msg_level;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   irq_route_ctrl #(.NPINS(NPINS)) dut (
      .clk (clk), .rst_n (rst_n),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .irq_in (irq_in),
      .msg_valid (msg_valid), .msg_ready (msg_ready),
      .msg_vector (msg_vector), .msg_dest (msg_dest), .msg_mode (msg_mode),
      .msg_dest_logical (msg_dest_logical), .msg_level (msg_level)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   task automatic do_pin(input logic [31:0] v);
      @(negedge clk);
      irq_in = v[NPINS-1:0];
   endtask

   task automatic do_msg(input logic [31:0] exp, input bit ack, input string tag);
      logic [31:0] act;
      @(negedge clk);
      act = {12'b0, msg_valid, msg_mode, msg_dest, msg_vector};
      check(act == {12'b0, 1'b1, exp[18:0]}, tag, act, {12'b0, 1'b1, exp[18:0]});
      if (ack) begin
         msg_ready = 1'b1;
         @(negedge clk);
         msg_ready = 1'b0;
      end
   endtask

   task automatic do_nomsg(input string tag);
      @(negedge clk);
      @(negedge clk);
      check(!msg_valid, tag, {31'b0, msg_valid}, 32'h0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4: state straight after reset
      @(negedge clk);
      check(!msg_valid, "R4 valid after reset", {31'b0, msg_valid}, 32'h0);
      do_rd(8'h00, 32'h0, "R4 index after reset");

      for (int i = 0; i < N_VEC; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i][75:72], i);
         case (VECS[i][79:76])
            OP_WR:  do_wr(VECS[i][71:64], VECS[i][63:32]);
            OP_RD:  do_rd(VECS[i][71:64], VECS[i][31:0], tag);
            OP_PIN: do_pin(VECS[i][63:32]);
            OP_MSG: do_msg(VECS[i][31:0], 1'b1, tag);
            OP_NOM: do_nomsg(tag);
            default: ;
         endcase
      end

      // R12: high word first, then unmask; held message ignores later edits
      do_pin(32'h00000010);
      do_wr(8'h00, 32'h19);
      do_wr(8'h10, 32'h0A000000);
      do_nomsg("R12 masked during high write");
      do_wr(8'h00, 32'h18);
      do_wr(8'h10, 32'h00008044);
      do_msg(32'h00000A44, 1'b0, "R12 complete entry");
      do_wr(8'h00, 32'h19);
      do_wr(8'h10, 32'h0B000000);
      do_msg(32'h00000A44, 1'b0, "R12 held while not ready");
      do_msg(32'h00000A44, 1'b1, "R12 taken unchanged");
      do_pin(32'h0);
      do_wr(8'h40, 32'h44);

      // R13: SMI code read back, and mode carried in the message
      do_wr(8'h00, 32'h22);
      do_wr(8'h10, 32'h00010255);
      do_rd(8'h10, 32'h00010255, "R13 SMI readback");
      do_wr(8'h00, 32'h1C);
      do_wr(8'h10, 32'h00008566);
      do_pin(32'h00000040);
      do_msg(32'h00050066, 1'b1, "R13 mode in message");
      do_pin(32'h0);
      do_wr(8'h40, 32'h66);

      // R4: reset mid-run with a request waiting
      do_pin(32'h00000040);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      do_nomsg("R4 masked after reset");
      do_rd(8'h00, 32'h0, "R4 index cleared");
      do_wr(8'h00, 32'h1C);
      do_rd(8'h10, 32'h00010000, "R4 entry masked");

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule